// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block sits between a set of numbered interrupt sources and a CPU. Peripherals pulse a per-source raise strobe to mark a source pending, and a per-source clear strobe to withdraw it. Each source has a programmable priority. The block selects the pending source with the highest priority and drives a request line to the CPU. When the CPU pulses accept, the block returns the fixed 12-bit exception code of the selected source.

The CPU supplies a 4-bit mask level and a block bit. Both gate the request combinationally, so a change in either is seen in the same cycle. At reset, every priority is loaded from a fixed default set. After reset, a one-entry-per-cycle write port (source index and value) changes individual priorities. A priority of zero disables a source: a raise for that source is refused.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The exception code of source n is fixed, with these values:
  - n in 0..14: 0x200 + 0x20*n
  - n = 15: 0x1C0
  - n in 16..22: 0x600 + 0x20*(n-16)
  - n in 23..33: 0x400 + 0x20*(n-23)
  - n in 34..37: 0x700 + 0x20*(n-34)
  - n in 38..40: 0x560 + 0x20*(n-38)
- R2: The reset value of each 5-bit priority is:
  - sources 0..14: 15-n
  - source 15: 16
  - all other sources: 0
- R3: A raise for a source whose current priority is 0 is ignored, and that source does not become pending.
- R4: A source is pending at most once. A repeated raise of a pending source has no effect, and a single clear removes it.
- R5: The selected source is the pending source with the largest priority value. On equal priorities, the lowest index wins.
- R6: `irq_req` is high exactly when all three of these hold:
  - some source is pending;
  - `cpu_block` is 0;
  - `cpu_mask` is strictly less than the selected source's priority.
- R7: A clear removes the source from the pending set at the next edge. `irq_req` reflects the new set from that cycle on.
- R8: A change of `cpu_mask` or `cpu_block` affects `irq_req` in the same cycle, with no clock edge needed.
- R9: While `rst_n` is low at an edge, the pending set empties, `irq_req` goes low, `code_o` goes to 0 and the priorities reload.
- R10: When `accept` is high at an edge, `code_o` takes the code of the source selected before that edge. `code_o` is valid in the following cycle and holds until the next accept.
- R11: A raise and a clear of the same source in the same cycle leave the source not pending.
- R12: A priority write with `prio_we` high sets the priority of source `prio_idx` to `prio_wdata` at the edge. An index of 41 or more changes nothing. A raise in the same cycle as a write uses the old priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_i | input | 41 | Per-source raise strobes |
| clear_i | input | 41 | Per-source clear strobes |
| prio_we | input | 1 | Priority write enable |
| prio_idx | input | 6 | Source index for the priority write |
| prio_wdata | input | 5 | New priority value |
| cpu_mask | input | 4 | CPU interrupt mask level |
| cpu_block | input | 1 | CPU block bit; 1 suppresses the request |
| accept | input | 1 | CPU accepts the current request |
| irq_req | output | 1 | Interrupt request to the CPU |
| code_o | output | 12 | Exception code of the accepted source |

## Verification
The hardest situation to reach from the ports is several sources pending at once with equal, reprogrammed priorities, while the mask sits exactly at the selected priority. Equal priorities exercise the lowest-index tie-break, and a mask at the selected priority exercises the strict compare.

Random priority writes over a small value range make ties common. Sparse random raises keep several sources pending over many cycles, and a random mask sweeps every level. Directed sequences add four cases:
- a forced tie;
- a raise and a clear together on one source;
- a raise of a zero-priority source;
- a sweep of every source's code.

// File: rtl/irqc_pkg.sv
// Package: shared constants and fixed tables for the interrupt controller.
// Assumes the 41-source numbering used throughout the block.
package irqc_pkg;

    localparam int CODE_W = 12;
    localparam int DPRIO_W = 5;

    // Fixed exception code of source n.
    function automatic logic [CODE_W-1:0] irqc_code(input int n);
        int base;
        int off;
        if (n < 15) begin
            base = 'h200; off = n;
        end else if (n == 15) begin
            base = 'h1C0; off = 0;
        end else if (n < 23) begin
            base = 'h600; off = n - 16;
        end else if (n < 34) begin
            base = 'h400; off = n - 23;
        end else if (n < 38) begin
            base = 'h700; off = n - 34;
        end else begin
            base = 'h560; off = n - 38;
        end
        return CODE_W'(base + 'h20 * off);
    endfunction

    // Reset priority of source n.
    function automatic logic [DPRIO_W-1:0] irqc_default_prio(input int n);
        if (n < 15)
            return DPRIO_W'(15 - n);
        else if (n == 15)
            return DPRIO_W'(16);
        else
            return '0;
    endfunction

endpackage

// File: rtl/irqc_prio_bank.sv
// Module: per-source priority registers.
// Each register loads its default on reset and is written one entry per cycle.
// Assumes out-of-range write indices are dropped.
module irqc_prio_bank #(
    parameter int NUM_SRC = 41,
    parameter int PRIO_W  = 5,
    parameter int IDX_W   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [PRIO_W-1:0]                wr_val,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o
);
    import irqc_pkg::*;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        localparam logic [PRIO_W-1:0] DEF = PRIO_W'(irqc_default_prio(g));

        // Hold one source's priority: default on reset, else write when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_o[g] <= DEF;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                prio_o[g] <= wr_val;
        end
    end

endmodule

// File: rtl/irqc_pend_set.sv
// Module: pending-source set, one flag per source.
// A clear beats a raise; a raise needs a non-zero current priority.
module irqc_pend_set #(
    parameter int NUM_SRC = 41,
    parameter int PRIO_W  = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               raise_i,
    input  logic [NUM_SRC-1:0]               clear_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_i,
    output logic [NUM_SRC-1:0]               pend_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
        // Update one pending flag from its strobes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (clear_i[g])
                pend_o[g] <= 1'b0;
            else if (raise_i[g] && (prio_i[g] != '0))
                pend_o[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/irqc_select.sv
// Module: combinational winner selection over the pending set.
// Picks the largest priority; a strict compare scanning upward keeps the
// lowest index on ties.
module irqc_select #(
    parameter int NUM_SRC = 41,
    parameter int PRIO_W  = 5,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0]               pend_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_i,
    output logic                             any_o,
    output logic [IDX_W-1:0]                 idx_o,
    output logic [PRIO_W-1:0]                prio_o
);

    // Scan all sources and keep the best pending one.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && (!any_o || (prio_i[i] > prio_o))) begin
                any_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the prioritised interrupt controller.
// Gates the request with the CPU block bit and a strict mask compare, and
// registers the exception code on accept.
// Assumes accept is only pulsed while a source is pending.
module prio_irq_ctrl #(
    parameter int NUM_SRC = 41,
    parameter int PRIO_W  = 5,
    parameter int MASK_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   raise_i,
    input  logic [NUM_SRC-1:0]   clear_i,
    input  logic                 prio_we,
    input  logic [IDX_W-1:0]     prio_idx,
    input  logic [PRIO_W-1:0]    prio_wdata,
    input  logic [MASK_W-1:0]    cpu_mask,
    input  logic                 cpu_block,
    input  logic                 accept,
    output logic                 irq_req,
    output logic [11:0]          code_o
);
    import irqc_pkg::*;

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0]             pend_q;
    logic                           sel_any;
    logic [IDX_W-1:0]               sel_idx;
    logic [PRIO_W-1:0]              sel_prio;

    irqc_prio_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (prio_we),
        .wr_idx (prio_idx),
        .wr_val (prio_wdata),
        .prio_o (prio_q)
    );

    irqc_pend_set #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (raise_i),
        .clear_i (clear_i),
        .prio_i  (prio_q),
        .pend_o  (pend_q)
    );

    irqc_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
        .pend_i (pend_q),
        .prio_i (prio_q),
        .any_o  (sel_any),
        .idx_o  (sel_idx),
        .prio_o (sel_prio)
    );

    // Request to the CPU: something pending, not blocked, mask below priority.
    always_comb begin
        irq_req = sel_any && !cpu_block && (PRIO_W'(cpu_mask) < sel_prio);
    end

    // Capture the selected source's code when the CPU accepts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_o <= '0;
        else if (accept)
            code_o <= irqc_code(int'(sel_idx));
    end

endmodule

// File: rtl/prio_irq_ctrl_checker.sv
// Module: assertion checker for the interrupt controller, bound to the top.
module prio_irq_ctrl_checker #(
    parameter int NUM_SRC = 41,
    parameter int PRIO_W  = 5,
    parameter int IDX_W   = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_SRC-1:0]               raise_i,
    input logic [NUM_SRC-1:0]               clear_i,
    input logic                             accept,
    input logic                             cpu_block,
    input logic                             irq_req,
    input logic [11:0]                      code_o,
    input logic [NUM_SRC-1:0]               pend_q,
    input logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q,
    input logic                             sel_any,
    input logic [IDX_W-1:0]                 sel_idx
);
    logic [NUM_SRC-1:0] prio_nz;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_nz
        assign prio_nz[g] = (prio_q[g] != '0);
    end

    p_req_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q != '0));

    p_block_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_block |-> !irq_req);

    p_zero_prio_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(raise_i) & $past(prio_nz))) == '0));

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clear_i)) == '0));

    p_code_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(code_o));

    p_reset_empties_r9: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0) && !irq_req);

    p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> pend_q[sel_idx]);

    p_accept_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> sel_any);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_i   (raise_i),
    .clear_i   (clear_i),
    .accept    (accept),
    .cpu_block (cpu_block),
    .irq_req   (irq_req),
    .code_o    (code_o),
    .pend_q    (pend_q),
    .prio_q    (prio_q),
    .sel_any   (sel_any),
    .sel_idx   (sel_idx)
);

// File: tb/prio_irq_ctrl_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a bench-side model of the requirements.
module prio_irq_ctrl_bench;

    localparam int NS = 41;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] raise_i = '0;
    logic [NS-1:0] clear_i = '0;
    logic          prio_we = 1'b0;
    logic [5:0]    prio_idx = '0;
    logic [4:0]    prio_wdata = '0;
    logic [3:0]    cpu_mask = '0;
    logic          cpu_block = 1'b0;
    logic          accept = 1'b0;
    logic          irq_req;
    logic [11:0]   code_o;

    int n_checks = 0;
    int n_fail = 0;
    bit m_pend [NS];
    int m_prio [NS];

    always #5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .clear_i(clear_i),
        .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
        .cpu_mask(cpu_mask), .cpu_block(cpu_block), .accept(accept),
        .irq_req(irq_req), .code_o(code_o)
    );

    // R1 code table, written from the requirement.
    function automatic int exp_code(int n);
        if (n < 15)      return 'h200 + 'h20 * n;
        else if (n == 15) return 'h1C0;
        else if (n < 23) return 'h600 + 'h20 * (n - 16);
        else if (n < 34) return 'h400 + 'h20 * (n - 23);
        else if (n < 38) return 'h700 + 'h20 * (n - 34);
        else             return 'h560 + 'h20 * (n - 38);
    endfunction

    // R2 defaults.
    function automatic int def_prio(int n);
        if (n < 15) return 15 - n;
        if (n == 15) return 16;
        return 0;
    endfunction

    // R5 selection: index of winner or -1.
    function automatic int model_sel();
        int best = -1;
        for (int i = 0; i < NS; i++)
            if (m_pend[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        return best;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_pend[i] = 1'b0;
            m_prio[i] = def_prio(i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; raise_i = '0; clear_i = '0; prio_we = 1'b0; accept = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R9 irq_req after reset", int'(irq_req), 0);
        check("R9 code_o after reset", int'(code_o), 0);
    endtask

    // One cycle: drive, check request (R6, R8), clock, check code (R10), update model.
    task automatic step(string tag, logic [NS-1:0] r, logic [NS-1:0] c,
                        logic we, int widx, int wval, int mask, logic blk, logic acc);
        int sel;
        int ecode;
        int ereq;
        @(negedge clk);
        sel = model_sel();
        if (sel < 0) acc = 1'b0;
        raise_i = r; clear_i = c; prio_we = we;
        prio_idx = 6'(widx); prio_wdata = 5'(wval);
        cpu_mask = 4'(mask); cpu_block = blk; accept = acc;
        #1;
        ereq = (sel >= 0 && !blk && mask < m_prio[sel]) ? 1 : 0;
        check({tag, " R6 irq_req"}, int'(irq_req), ereq);
        ecode = (sel >= 0) ? exp_code(sel) : 0;
        @(posedge clk);
        #1;
        if (acc) check({tag, " R10 code_o"}, int'(code_o), ecode);
        for (int i = 0; i < NS; i++) begin
            if (c[i]) m_pend[i] = 1'b0;
            else if (r[i] && m_prio[i] != 0) m_pend[i] = 1'b1;
        end
        if (we && widx < NS) m_prio[widx] = wval & 31;
        raise_i = '0; clear_i = '0; prio_we = 1'b0; accept = 1'b0;
    endtask

    function automatic logic [NS-1:0] bit_of(int n);
        logic [NS-1:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R2: source 0 default 15, mask 14 requests, mask 15 does not.
        step("R2 raise s0", bit_of(0), '0, 0, 0, 0, 14, 0, 0);
        step("R2 mask14", '0, '0, 0, 0, 0, 14, 0, 1);
        step("R2 mask15", '0, '0, 0, 0, 0, 15, 0, 0);
        // R8: block bit and mask change take effect in the same cycle.
        step("R8 block", '0, '0, 0, 0, 0, 0, 1, 0);
        step("R8 unblock", '0, '0, 0, 0, 0, 0, 0, 0);
        // R4: repeated raise, then a single clear empties the source.
        step("R4 reraise", bit_of(0), '0, 0, 0, 0, 0, 0, 0);
        step("R4 clear", '0, bit_of(0), 0, 0, 0, 0, 0, 0);
        step("R4 R7 after clear", '0, '0, 0, 0, 0, 0, 0, 0);
        // R3: source 20 has priority 0, raise refused.
        step("R3 raise zero", bit_of(20), '0, 0, 0, 0, 0, 0, 0);
        step("R3 check", '0, '0, 0, 0, 0, 0, 0, 0);
        // R11: raise and clear together on source 5.
        step("R11 both", bit_of(5), bit_of(5), 0, 0, 0, 0, 0, 0);
        step("R11 check", '0, '0, 0, 0, 0, 0, 0, 0);
        // R12 and R5: write prio of source 3 to 9, tie with source 6.
        step("R12 write", '0, '0, 1, 3, 9, 0, 0, 0);
        step("R12 bad idx", '0, '0, 1, 45, 31, 0, 0, 0);
        step("R5 tie raise", bit_of(3) | bit_of(6), '0, 0, 0, 0, 0, 0, 0);
        step("R5 tie accept", '0, '0, 0, 0, 0, 8, 0, 1);
        step("R5 tie mask9", '0, '0, 0, 0, 0, 9, 0, 0);
        step("R5 clear", '0, bit_of(3) | bit_of(6), 0, 0, 0, 0, 0, 0);

        // R1: every source's code.
        for (int i = 0; i < NS; i++) begin
            step("R1 set", '0, '0, 1, i, 20, 0, 0, 0);
            step("R1 raise", bit_of(i), '0, 0, 0, 0, 0, 0, 0);
            step("R1 accept", '0, '0, 0, 0, 0, 0, 0, 1);
            step("R1 clear", '0, bit_of(i), 0, 0, 0, 0, 0, 0);
        end

        do_reset();

        // Random phase with a mid-run reset.
        for (int k = 0; k < 1500; k++) begin
            logic [NS-1:0] r = '0;
            logic [NS-1:0] c = '0;
            if (k == 750) do_reset();
            for (int i = 0; i < NS; i++) begin
                r[i] = ($urandom % 24) == 0;
                c[i] = ($urandom % 40) == 0;
            end
            step("RND", r, c, ($urandom % 6) == 0, int'($urandom % 48),
                 int'($urandom % 8) + (($urandom % 4 == 0) ? 12 : 0),
                 int'($urandom % 16), ($urandom % 6) == 0, ($urandom % 4) == 0);
        end

        finish_run();
    end

endmodule